// File: doc/BRIEF.md
# Multi-Core Interrupt Router

This block gathers two groups of up to 64 interrupt sources and fans them out to several processor cores. Every core owns two interrupt lines: line 0 is the AND of the group-0 summary seen by that core with the core's group-0 enable mask, reduced by OR; line 1 does the same with the shared group-1 summary and the core's group-1 enable mask. Software steers each source to any subset of cores by programming the enable registers, which sit two per core.

Enable registers can be written whole, or changed one bit at a time through a set alias and a clear alias, so that no read-modify-write (and no lock between cores) is needed. A chosen subset of group-0 sources is sticky: such a bit latches on the rising edge of its source, separately for every core, and stays set until that core writes a 1 to the bit in its own group-0 summary register. The other group-0 bits, and all of group 1, follow their inputs directly.

A small request bus reaches every register. A read is answered one cycle later by a two-state response machine: ST_IDLE (no response pending) and ST_RESP (response valid this cycle). The transition T_ACCEPT enters ST_RESP from either state when a read is presented; T_DRAIN returns to ST_IDLE when no read is presented.

Top module: `irq_route_unit`

## Requirements
- R1: After reset every enable register and every sticky bit is zero, all interrupt lines are low and `rsp_valid` is low.
- R2: For core c, `irq_line0[c]` is high exactly when the group-0 summary of core c ANDed with enable register 2c is nonzero, and `irq_line1[c]` is high exactly when `src_g1` ANDed with enable register 2c+1 is nonzero; both lines react in the same cycle as their inputs.
- R3: The address is {kind[2:0], index}, index being $clog2(2*NUM_CORES) bits; a write with kind 0 replaces enable register `index` with the write data.
- R4: A write with kind 1 (set alias) ORs the write data into enable register `index`; zero bits leave it unchanged.
- R5: A write with kind 2 (clear alias) clears the enable bits that are 1 in the write data; zero bits leave it unchanged.
- R6: Group-0 bits not in STICKY_MASK read and route as the current level of `src_g0`.
- R7: Group-0 bits in STICKY_MASK set in every core's copy on a rising edge of the source (source high now, low in the previous cycle) and stay set after the source falls.
- R8: A write with kind 3 clears the sticky bits that are 1 in the data in the copy of core index>>1 only; other cores' copies and non-sticky bits are unaffected, and a write with kind 4 changes nothing.
- R9: When a rising edge and a clear write hit the same sticky bit in the same cycle, the bit ends up set.
- R10: A read is answered in the next cycle with `rsp_valid` high for one cycle; kinds 0, 1 and 2 return enable register `index`, kind 3 returns the group-0 summary of core index>>1, kind 4 returns `src_g1`, kinds 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_g0 | input | SRC_W | Group-0 source levels |
| src_g1 | input | SRC_W | Group-1 source levels |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | $clog2(2*NUM_CORES)+3 | {kind, index} register address |
| req_wdata | input | SRC_W | Write data or mask |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | SRC_W | Read data |
| irq_line0 | output | NUM_CORES | Per-core line fed by group 0 |
| irq_line1 | output | NUM_CORES | Per-core line fed by group 1 |

## Verification
The assertions watch every cycle that each read gets its response one cycle later and that no response appears without a read, that a whole-mask set or clear on core 0's group-1 register immediately decides core 0's second line, that a zero write to core 0's group-0 register silences its first line, and that no second line rises without some group-1 source. The per-core sticky latching, the precedence of an edge over a clear, the isolation of one core's clear from the others and the value returned by each address kind depend on history and data, so only the bench's directed and random scenarios, compared against its own model, can show them.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Register kind carried in the upper address bits.
    typedef enum logic [2:0] {
        K_EN   = 3'd0,
        K_SET  = 3'd1,
        K_CLR  = 3'd2,
        K_SUM0 = 3'd3,
        K_SUM1 = 3'd4
    } reg_kind_e;

    // Read response machine.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank
    import irq_route_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int W        = 64,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_kind_e        wr_kind,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     en_q [NUM_REGS]
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[r] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(r)) begin
                unique case (wr_kind)
                    K_EN:    en_q[r] <= wr_data;
                    K_SET:   en_q[r] <= en_q[r] | wr_data;
                    K_CLR:   en_q[r] <= en_q[r] & ~wr_data;
                    default: en_q[r] <= en_q[r];
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_sum_unit.sv
module irq_sum_unit #(
    parameter int             NUM_CORES   = 4,
    parameter int             W           = 64,
    parameter int             CORE_W      = 2,
    parameter logic [W-1:0]   STICKY_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      src_g0,
    input  logic              clr_valid,
    input  logic [CORE_W-1:0] clr_core,
    input  logic [W-1:0]      clr_mask,
    output logic [W-1:0]      sum0 [NUM_CORES]
);

    logic [W-1:0] src_q;
    logic [W-1:0] rise_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_g0;
    end

    assign rise_st = src_g0 & ~src_q & STICKY_MASK;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [W-1:0] sticky_q;
        logic         hit;

        assign hit = clr_valid && clr_core == CORE_W'(c);

        // an edge in the same cycle as a clear leaves the bit set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sticky_q <= '0;
            else        sticky_q <= (sticky_q & ~(hit ? clr_mask : '0)) | rise_st;
        end

        assign sum0[c] = (src_g0 & ~STICKY_MASK) | sticky_q;
    end

endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int                NUM_CORES   = 4,
    parameter int                SRC_W       = 64,
    parameter logic [SRC_W-1:0]  STICKY_MASK = 64'h0000_0000_00F0_000F,
    localparam int               IDX_W       = $clog2(2 * NUM_CORES),
    localparam int               ADDR_W      = IDX_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_W-1:0]     src_g0,
    input  logic [SRC_W-1:0]     src_g1,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SRC_W-1:0]     req_wdata,
    output logic                 rsp_valid,
    output logic [SRC_W-1:0]     rsp_rdata,
    output logic [NUM_CORES-1:0] irq_line0,
    output logic [NUM_CORES-1:0] irq_line1
);

    localparam int NUM_REGS = 2 * NUM_CORES;
    localparam int CORE_W   = IDX_W - 1;

    reg_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic [CORE_W-1:0]  core;
    logic               wr_req;
    logic               rd_req;
    logic [SRC_W-1:0]   en_q [NUM_REGS];
    logic [SRC_W-1:0]   sum0 [NUM_CORES];
    logic [SRC_W-1:0]   rd_sel;
    logic [SRC_W-1:0]   rdata_q;
    rd_state_e          state_q;
    rd_state_e          state_d;

    assign kind   = reg_kind_e'(req_addr[ADDR_W-1:IDX_W]);
    assign idx    = req_addr[IDX_W-1:0];
    assign core   = idx[IDX_W-1:1];
    assign wr_req = req_valid && req_write;
    assign rd_req = req_valid && !req_write;

    irq_en_bank #(
        .NUM_REGS (NUM_REGS),
        .W        (SRC_W),
        .IDX_W    (IDX_W)
    ) u_en_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_req && (kind == K_EN || kind == K_SET || kind == K_CLR)),
        .wr_kind (kind),
        .wr_idx  (idx),
        .wr_data (req_wdata),
        .en_q    (en_q)
    );

    irq_sum_unit #(
        .NUM_CORES   (NUM_CORES),
        .W           (SRC_W),
        .CORE_W      (CORE_W),
        .STICKY_MASK (STICKY_MASK)
    ) u_sum_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_g0    (src_g0),
        .clr_valid (wr_req && kind == K_SUM0),
        .clr_core  (core),
        .clr_mask  (req_wdata),
        .sum0      (sum0)
    );

    // two lines per core: even register feeds line 0, odd register line 1
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_lines
        assign irq_line0[c] = |(sum0[c] & en_q[2*c]);
        assign irq_line1[c] = |(src_g1  & en_q[2*c+1]);
    end

    always_comb begin
        rd_sel = '0;
        unique case (kind)
            K_EN, K_SET, K_CLR: if (int'(idx) < NUM_REGS)   rd_sel = en_q[idx];
            K_SUM0:             if (int'(core) < NUM_CORES) rd_sel = sum0[core];
            K_SUM1:             rd_sel = src_g1;
            default:            rd_sel = '0;
        endcase
    end

    // next state: T_ACCEPT on a read, T_DRAIN otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= rd_sel;
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rdata_q;
    end

endmodule

module irq_route_chk #(
    parameter int NUM_CORES = 4,
    parameter int SRC_W     = 64,
    parameter int IDX_W     = 3,
    parameter int ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [SRC_W-1:0]     req_wdata,
    input logic [SRC_W-1:0]     src_g1,
    input logic                 rsp_valid,
    input logic [NUM_CORES-1:0] irq_line0,
    input logic [NUM_CORES-1:0] irq_line1
);

    localparam logic [ADDR_W-1:0] A_EN0  = ADDR_W'({3'd0, IDX_W'(0)});
    localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'({3'd1, IDX_W'(1)});
    localparam logic [ADDR_W-1:0] A_CLR1 = ADDR_W'({3'd2, IDX_W'(1)});

    // R10
    rd_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid);

    // R10
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R4
    set_all_routes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == A_SET1 && (&req_wdata)
        |=> irq_line1[0] == (|src_g1));

    // R5
    clr_all_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == A_CLR1 && (&req_wdata)
        |=> !irq_line1[0]);

    // R3
    zero_write_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr == A_EN0 && req_wdata == '0
        |=> !irq_line0[0]);

    // R2
    line1_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line1 != '0 |-> (|src_g1));

endmodule

bind irq_route_unit irq_route_chk #(
    .NUM_CORES (NUM_CORES),
    .SRC_W     (SRC_W),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
) u_route_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .src_g1    (src_g1),
    .rsp_valid (rsp_valid),
    .irq_line0 (irq_line0),
    .irq_line1 (irq_line1)
);

// File: tb/test_irq_route_unit.sv
module test_irq_route_unit;

    localparam int          NC     = 4;
    localparam logic [63:0] STICKY = 64'h0000_0000_00F0_000F;
    localparam logic [63:0] ONES   = {64{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_g0 = '0, src_g1 = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [NC-1:0] irq_line0, irq_line1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [63:0] m_en [2*NC];
    logic [63:0] m_st [NC];
    logic [63:0] m_srcq;

    always #2 clk = ~clk;

    irq_route_unit #(.NUM_CORES(NC), .SRC_W(64), .STICKY_MASK(STICKY)) i_irq_route_unit (
        .clk(clk), .rst_n(rst_n), .src_g0(src_g0), .src_g1(src_g1),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_line0(irq_line0), .irq_line1(irq_line1)
    );

    function automatic logic [5:0] a(input int kind, input int idx);
        return {3'(kind), 3'(idx)};
    endfunction

    function automatic logic [63:0] f_sum0(input int c, input logic [63:0] s0);
        return (s0 & ~STICKY) | m_st[c];
    endfunction

    function automatic logic [7:0] f_lines(input logic [63:0] s0, input logic [63:0] s1);
        logic [7:0] v;
        for (int c = 0; c < NC; c++) begin
            v[c]      = |(f_sum0(c, s0) & m_en[2*c]);
            v[NC + c] = |(s1 & m_en[2*c+1]);
        end
        return v;
    endfunction

    function automatic logic [63:0] f_read(input logic [5:0] ad, input logic [63:0] s0,
                                           input logic [63:0] s1);
        int k = int'(ad[5:3]);
        int i = int'(ad[2:0]);
        if (k <= 2) return m_en[i];
        if (k == 3) return f_sum0(i >> 1, s0);
        if (k == 4) return s1;
        return '0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic cyc(input logic v, input logic w, input logic [5:0] ad,
                       input logic [63:0] wd, input logic [63:0] s0,
                       input logic [63:0] s1, input string tag);
        logic [63:0] exp_rd;
        logic [63:0] n_en [2*NC];
        logic [63:0] n_st [NC];
        logic [63:0] rise;
        int k = int'(ad[5:3]);
        int i = int'(ad[2:0]);
        req_valid = v; req_write = w; req_addr = ad; req_wdata = wd;
        src_g0 = s0; src_g1 = s1;
        #1;
        check("R2 lines", {56'd0, irq_line1, irq_line0}, {56'd0, f_lines(s0, s1)});
        exp_rd = f_read(ad, s0, s1);
        n_en = m_en;
        n_st = m_st;
        if (v && w) begin
            if (k == 0) n_en[i] = wd;
            if (k == 1) n_en[i] = m_en[i] | wd;
            if (k == 2) n_en[i] = m_en[i] & ~wd;
            if (k == 3) n_st[i >> 1] = m_st[i >> 1] & ~wd;
        end
        rise = s0 & ~m_srcq & STICKY;
        for (int c = 0; c < NC; c++) n_st[c] = n_st[c] | rise;
        @(posedge clk);
        m_en = n_en;
        m_st = n_st;
        m_srcq = s0;
        @(negedge clk);
        if (v && !w) begin
            check({tag, " rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
            check({tag, " rdata"}, rsp_rdata, exp_rd);
        end else begin
            check("R10 no response", {63'd0, rsp_valid}, 64'd0);
        end
    endtask

    task automatic wr(input logic [5:0] ad, input logic [63:0] wd, input string tag);
        cyc(1'b1, 1'b1, ad, wd, src_g0, src_g1, tag);
    endtask

    task automatic rd(input logic [5:0] ad, input string tag);
        cyc(1'b1, 1'b0, ad, '0, src_g0, src_g1, tag);
    endtask

    task automatic idle(input logic [63:0] s0, input logic [63:0] s1);
        cyc(1'b0, 1'b0, '0, '0, s0, s1, "R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int r = 0; r < 2*NC; r++) m_en[r] = '0;
        for (int c = 0; c < NC; c++) m_st[c] = '0;
        m_srcq = '0;

        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 lines in reset", {56'd0, irq_line1, irq_line0}, 64'd0);
        check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;

        // R1: registers zero after reset
        rd(a(0, 2), "R1");
        rd(a(3, 4), "R1");

        // R3 whole write, R4 set alias, R5 clear alias
        wr(a(0, 0), 64'hFF00, "R3");
        rd(a(0, 0), "R3");
        wr(a(1, 0), 64'h00FF, "R4");
        rd(a(1, 0), "R4");
        wr(a(2, 0), 64'h0F0F, "R5");
        rd(a(2, 0), "R5");

        // R6 level bit 12 follows the source
        idle(64'h1000, '0);
        check("R6 line0 core0", {63'd0, irq_line0[0]}, 64'd1);
        src_g0 = 64'h1000;
        rd(a(3, 0), "R6");
        idle('0, '0);
        rd(a(3, 0), "R6");

        // R7 sticky bit 0: pulse, then held in every core copy
        wr(a(1, 2), 64'h1, "R7");
        idle(64'h1, '0);
        idle('0, '0);
        rd(a(3, 2), "R7");
        rd(a(3, 6), "R7");
        check("R7 line0 core1 held", {63'd0, irq_line0[1]}, 64'd1);

        // R8 clear core1 copy only; sum1 writes ignored
        wr(a(3, 2), ONES, "R8");
        rd(a(3, 2), "R8");
        rd(a(3, 0), "R8");
        src_g1 = 64'h5;
        wr(a(4, 0), ONES, "R8");
        rd(a(4, 0), "R8");

        // R9 edge and clear in the same cycle: set wins
        cyc(1'b1, 1'b1, a(3, 0), 64'h1, 64'h1, 64'h5, "R9");
        rd(a(3, 0), "R9");
        idle('0, 64'h5);

        // R2 group-1 routing to core1 only
        wr(a(0, 3), 64'h4, "R2");
        idle('0, 64'h4);
        check("R2 line1 core1", {60'd0, irq_line1}, 64'h2);

        // R10 unused kind reads zero, back-to-back reads
        rd(a(5, 1), "R10");
        rd(a(0, 3), "R10");
        rd(a(4, 0), "R10");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] s0, s1, wd;
            logic v, w;
            logic [5:0] ad;
            v  = ($urandom % 3) != 0;
            w  = $urandom % 2;
            ad = a($urandom % 6, $urandom % 8);
            wd = {$urandom, $urandom} & {$urandom, $urandom};
            s0 = (($urandom % 4) == 0) ? {$urandom, $urandom} : src_g0;
            s1 = (($urandom % 4) == 0) ? ({$urandom, $urandom} & {$urandom, $urandom}) : src_g1;
            cyc(v, w, ad, wd, s0, s1, "R10 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule